// File: doc/BRIEF.md
# Latchable-Registered Bus Driver

This block drives an 18-bit output bus from an 18-bit input bus through one storage element per bit. A mode input selects how that element behaves: while it is high the element is transparent and the output follows the input with no clock involved. While it is low the element is an edge register that loads the input on each rising clock edge and holds it in between, whatever the input does.

Each storage bit is built from two level-sensitive stages in series. The front stage is open while the clock is low or the mode input is high. The back stage is open while the clock is high or the mode input is high. So a fall of the mode input freezes the last transparent value whatever the clock level is at that moment, and the next rising edge then takes over.

An active-low enable sets the output drivers only. When it is high, every output bit floats. The stored data and the capture path are not affected, so a word can be loaded while the bus is released. Beside the floating bus, the block also gives the stored or transparent word and a drive flag as plain two-state outputs. An active-low reset clears the storage. The data path has no handshake: the bus is level-driven, and a valid/ready pair would have nothing to gate.

Top module: `latreg_bus_driver`

## Requirements
- R1: With `le` = 1, `rst_n` = 1 and `oe_n` = 0, `y` and `drv_data` equal `a` on all 18 bits, and they follow changes of `a` with no clock edge.
- R2: With `le` = 0, a rising edge of `clk` loads the value `a` has at that edge, and that value then appears on `drv_data` (and on `y` when enabled).
- R3: With `le` = 0 and `clk` held high, changes of `a` do not alter `drv_data` or `y`.
- R4: With `le` = 0 and `clk` held low, changes of `a` do not alter `drv_data` or `y`.
- R5: When `le` falls while `clk` is high, the output keeps the value `a` had just before the fall until the next rising edge of `clk`.
- R6: When `le` falls while `clk` is low, the output keeps the value `a` had just before the fall until the next rising edge of `clk`.
- R7: With `oe_n` = 1, every bit of `y` is high impedance and `drv_en` = 0, whatever `le`, `clk` and `a` are.
- R8: Changes of `oe_n` never alter the stored word, and rising edges with `le` = 0 still load `a` while `oe_n` = 1.
- R9: While `rst_n` = 0, the storage is cleared to all zeros, whatever `le`, `clk` and `a` are, and `drv_data` reads 0.
- R10: `drv_data` always carries the stored or transparent word, whatever `oe_n` is. `drv_en` equals the inverse of `oe_n`, and `y` equals `drv_data` whenever `drv_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low clear of the storage |
| clk | input | 1 | Capture clock, rising edge active in register mode |
| le | input | 1 | Mode select: 1 transparent, 0 edge register |
| oe_n | input | 1 | Active-low output drive enable |
| a | input | 18 | Input data bus |
| y | output | 18 | Output bus, high impedance when disabled |
| drv_data | output | 18 | Stored or transparent word, unaffected by enable |
| drv_en | output | 1 | High while the output bus is driven |

## Verification
Two things can happen in the same cycle: the bus is released and a word is captured. The bench raises `oe_n`, then applies rising edges with `le` low and new values on `a`. During those edges it checks that `y` floats, which shows up as all ones through weak pull-ups, while `drv_data` takes the new word. Lowering `oe_n` afterwards must put exactly that word on `y`. A behavioural model in the bench decides the expected word at every step, including an input that changes while the clock stands still and a mode fall in either clock phase.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  parameter int unsigned LBD_WIDTH = 18;

  typedef struct packed {
    logic front_open;
    logic back_open;
  } gate_t;
endpackage

// File: rtl/lbd_mode_ctrl.sv
module lbd_mode_ctrl
  import lbd_pkg::*;
(
  input  logic  clk,
  input  logic  le,
  output gate_t gates
);
  // Front stage follows input in low clock phase or flow mode;
  // back stage follows front stage in high clock phase or flow mode.
  always_comb begin
    gates.front_open = ~clk | le;
    gates.back_open  =  clk | le;
  end
endmodule

// File: rtl/lbd_cell.sv
module lbd_cell
  import lbd_pkg::*;
(
  input  logic  rst_n,
  input  gate_t gates,
  input  logic  d,
  output logic  q
);
  logic front_q;

  always_latch begin
    if (!rst_n)               front_q <= 1'b0;
    else if (gates.front_open) front_q <= d;
  end

  always_latch begin
    if (!rst_n)              q <= 1'b0;
    else if (gates.back_open) q <= front_q;
  end
endmodule

// File: rtl/lbd_out.sv
module lbd_out #(
  parameter int unsigned W = 18
) (
  input  logic         oe_n,
  input  logic [W-1:0] data,
  output logic [W-1:0] y,
  output logic         en
);
  assign en = ~oe_n;
  assign y  = en ? data : {W{1'bz}};
endmodule

// File: rtl/latreg_bus_driver.sv
module latreg_bus_driver
  import lbd_pkg::*;
#(
  parameter int unsigned WIDTH = LBD_WIDTH
) (
  input  logic             rst_n,
  input  logic             clk,
  input  logic             le,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] a,
  output logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] drv_data,
  output logic             drv_en
);
  localparam int unsigned LAST = WIDTH - 1;

  gate_t gates;

  lbd_mode_ctrl u_mode (
    .clk   (clk),
    .le    (le),
    .gates (gates)
  );

  for (genvar i = 0; i <= LAST; i++) begin : g_bit
    lbd_cell u_cell (
      .rst_n (rst_n),
      .gates (gates),
      .d     (a[i]),
      .q     (drv_data[i])
    );
  end

  lbd_out #(.W(WIDTH)) u_out (
    .oe_n (oe_n),
    .data (drv_data),
    .y    (y),
    .en   (drv_en)
  );
endmodule

// File: rtl/lbd_checker.sv
module lbd_checker #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         le,
  input logic         oe_n,
  input logic [W-1:0] a,
  input logic [W-1:0] y,
  input logic [W-1:0] drv_data,
  input logic         drv_en
);
  // R1: flow mode with drive on passes a straight to the bus
  a_r1_flow_through: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !oe_n) |-> (y == a));

  // R2: register mode held across an edge shows what the previous edge loaded
  a_r2_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !le && $past(!le)) |-> (drv_data == $past(a)));

  // R9: first edge after reset in register mode still shows the cleared word
  a_r9_clear_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !le) |-> (drv_data == '0));

  // R10: a driven bus carries the stored word
  a_r10_bus_match: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (y == drv_data));
endmodule

bind latreg_bus_driver lbd_checker #(.W(WIDTH)) u_chk (.*);

// File: tb/sim_latreg_bus_driver.sv
`timescale 1ns/1ps
module sim_latreg_bus_driver;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         rst_n, clk, le, oe_n;
  logic [W-1:0] a;
  wire  [W-1:0] y;
  logic [W-1:0] drv_data;
  logic         drv_en;
  logic [W-1:0] model;
  int errors = 0;
  int checks = 0;

  latreg_bus_driver u0 (
    .rst_n(rst_n), .clk(clk), .le(le), .oe_n(oe_n), .a(a),
    .y(y), .drv_data(drv_data), .drv_en(drv_en)
  );

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup (y[i]);
  end

  task automatic check(input string tag);
    logic [W-1:0] exp_y;
    exp_y = oe_n ? ONES : model;
    checks++;
    if (drv_data !== model || drv_en !== !oe_n || y !== exp_y) begin
      errors++;
      $display("FAIL %s: data=%h en=%b y=%h expected data=%h en=%b y=%h",
               tag, drv_data, drv_en, y, model, !oe_n, exp_y);
    end
  endtask

  task automatic set_a(input logic [W-1:0] v, input string tag);
    a = v;
    if (le && rst_n) model = v;
    #2 check(tag);
  endtask

  task automatic set_le(input logic v, input string tag);
    le = v;
    if (v && rst_n) model = a;
    #2 check(tag);
  endtask

  task automatic set_oe(input logic v, input string tag);
    oe_n = v;
    #2 check(tag);
  endtask

  // 50 MHz: each half period is 10 ns
  task automatic rise(input string tag);
    clk = 1'b1;
    if (rst_n) model = a;
    #5 check(tag);
    #5;
  endtask

  task automatic fall(input string tag);
    clk = 1'b0;
    #5 check(tag);
    #5;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; clk = 0; le = 0; oe_n = 0; a = 18'h15A5A; model = '0;
    #3 check("R9 reset state");
    rise("R9 edge during reset");
    le = 1; #2 check("R9 flow during reset");
    le = 0;
    fall("R9");
    rst_n = 1; #2 check("R9 after release");

    // R2 capture, then R4 hold with clock low
    set_a(18'h2AAAA, "R4 change while low");
    rise("R2 capture");
    fall("R2 after fall");
    set_a(18'h0F0F0, "R4 hold low");
    set_a(18'h3FFFF, "R4 hold low");
    // R3 hold with clock high
    rise("R2 capture 3FFFF");
    set_a(18'h00001, "R3 hold high");
    set_a(18'h20000, "R3 hold high");
    fall("R3");

    // R1 flow mode
    set_le(1, "R1 enter flow");
    set_a(18'h12345, "R1 follow");
    rise("R1 edge in flow");
    set_a(18'h3C3C3, "R1 follow high");

    // R5: fall of le while clk high
    set_a(18'h1B6DB, "R1");
    set_le(0, "R5 fall while high");
    set_a(18'h00000, "R5 ignore");
    fall("R5 hold low");
    set_a(18'h2D2D2, "R5 ignore low");
    rise("R2 capture after R5");

    // R6: fall of le while clk low, le high across an edge first
    fall("R6");
    set_le(1, "R1");
    rise("R1");
    fall("R1");
    set_a(18'h0AAA5, "R1");
    set_le(0, "R6 fall while low");
    set_a(18'h35550, "R6 ignore");
    rise("R6 next edge loads");
    fall("R6");

    // R7/R8: bus released, capture continues
    set_a(18'h00000, "R4");
    set_oe(1, "R7 release bus");
    rise("R8 capture while released");
    set_a(18'h3FFFF, "R7");
    fall("R7");
    set_oe(0, "R8 re-enable shows captured");
    set_oe(1, "R8 toggle keeps data");
    set_le(1, "R7 flow while released");
    set_a(18'h00F00, "R7");
    rise("R7");
    fall("R7");
    set_oe(0, "R8");

    // mixed patterns: le changes only in the low phase
    for (int k = 0; k < 60; k++) begin
      fall("R10");
      if (k % 3 == 0) set_le(logic'($urandom_range(0, 1)), "R10");
      if (k % 5 == 0) set_oe(logic'($urandom_range(0, 1)), "R10");
      set_a(W'($urandom), "R10");
      rise("R10");
      set_a(W'($urandom), "R10");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule